// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This unit produces a coarse approximation of 1/sqrt(x) for IEEE-754 binary64 operands. The fraction of every finite result has 8 significant bits. The same hardware serves binary32 operands. A single-precision value is first widened into the double format and estimated there. The result is then narrowed back into the low 32 bits of the result word.

The approximation comes from a 512-entry, 8-bit table that is computed while the design elaborates. The table is addressed by the parity of the operand's exponent together with its leading fraction bits. The result exponent is obtained as (3068 − e)/2. Zeros, infinities and NaNs bypass the table. Subnormal operands are normalised with a leading-zero count and a barrel shift before lookup.

An operand is presented with a valid strobe and a precision select. The result appears one clock later with its own valid strobe and holds until the next operand is accepted. The unit is meant to seed an iterative refinement loop elsewhere in the datapath.

Top module: `rsqrt_est`

## Requirements
- R1: After reset, outValid is 0 and outResult is 0. An operand accepted on a rising edge with inValid high produces outValid high and its result on the next edge. outValid is low after any edge where inValid was low.
- R2: While inValid is low, outResult does not change, whatever inOperand and inSingle do.
- R3: A double operand (inSingle = 0) with biased exponent e in 1..2046, sign s and fraction f[51:0] gives the result {s, ((3068 − e) >> 1)[10:0], T[k], 44'b0}. When e is odd, k = 128 + f[51:45]. When e is even, k = 256 + f[51:44].
- R4: Table entry T[k], for k in 128..511, is built as follows. Let a = 2k + 1 for k < 256 and a = 2·(k | 1) otherwise. Let c be the smallest integer ≥ 257 with a·c² ≥ 2^28. Then T[k] = (c >> 1) mod 256. Example: the double 1.0 gives 0x3FEFF00000000000.
- R5: A double zero of sign s gives {s, 11'h7FF, 52'b0}.
- R6: A double infinity of sign s gives {s, 63'b0}.
- R7: A double NaN is returned unchanged except that fraction bit 51 is set to 1.
- R8: A double subnormal with fraction f ≠ 0 and z leading zeros in f[51:0] is treated as exponent e = −z with fraction f << (z+1) truncated to 52 bits. The R3 rules then apply; the parity test uses the low bit of e in two's complement.
- R9: With inSingle = 1 only inOperand[31:0] is read and outResult[63:32] is 0. A normal single with exponent se and fraction g uses e = se + 896 and fraction {g, 29'b0} under the R3 rules. The result is {s, (E − 896)[7:0], T[k], 15'b0}, where E is the R3 result exponent. 0x41200000 gives 0x3EA18000.
- R10: In single mode, a zero of sign s gives {s, 8'hFF, 23'b0}, an infinity gives {s, 31'b0}, and a NaN is returned with bit 22 set, all in the low 32 bits.
- R11: A single subnormal with fraction g ≠ 0 and z leading zeros in {g, 29'b0} uses e = 896 − z and fraction ({g, 29'b0} << (z+1)) truncated to 52 bits, then follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| inSingle | input | 1 | 1 selects binary32 in the low half, 0 selects binary64 |
| inOperand | input | 64 | Operand bits |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outResult | output | 64 | Estimate, held between operands |

## Verification
Every internal fault shows at the ports on the edge right after the operand is taken, because the unit has a single register stage.

A wrong table entry corrupts only the 8 fraction bits of operands whose exponent parity and leading bits address that entry. Random normals of both parities are therefore needed to reach most of the table. A wrong leading-zero count or a wrong rebias changes both the exponent and the fraction of the result. Subnormal and single-precision operands are mixed in to expose those faults.

A broken special-value path returns a finite estimate where an infinity, zero or quiet NaN was due.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;
  localparam int DBL_W      = 64;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_W      = 32;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int EST_W      = 8;
  localparam int ROM_DEPTH  = 512;
  localparam int IDX_W      = $clog2(ROM_DEPTH);
  localparam int EXP_CALC_W = DBL_EXP_W + 2;
  localparam int LZ_W       = $clog2(DBL_FRAC_W + 1);
  localparam int REBIAS     = 896;
  localparam int EXP_MAGIC  = 3068;
  localparam int FRAC_PAD   = DBL_FRAC_W - SGL_FRAC_W;
  localparam int EST_LSB    = DBL_FRAC_W - EST_W;
  localparam int SGL_EST_LSB = SGL_FRAC_W - EST_W;
  localparam int SEARCH_LOG = 28;
  localparam int SEARCH_LO  = 257;
  localparam int SEARCH_HI  = 1025;

  typedef struct packed {
    logic capture;
    logic narrow;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    CLS_FINITE,
    CLS_ZERO,
    CLS_INF,
    CLS_NAN
  } opClass_t;

  typedef logic [ROM_DEPTH-1:0][EST_W-1:0] romImage_t;

  // Smallest c >= SEARCH_LO with a*c*c >= 2^SEARCH_LOG, found by bisection.
  function automatic romImage_t buildRomImage();
    romImage_t img;
    longint a;
    longint lo;
    longint hi;
    longint mid;
    img = '0;
    for (int idx = ROM_DEPTH / 4; idx < ROM_DEPTH; idx++) begin
      if (idx < ROM_DEPTH / 2) a = longint'(2 * idx + 1);
      else a = longint'(idx | 1) << 1;
      lo = SEARCH_LO;
      hi = SEARCH_HI;
      while (lo < hi) begin
        mid = (lo + hi) / 2;
        if (a * mid * mid >= (longint'(1) << SEARCH_LOG)) hi = mid;
        else lo = mid + 1;
      end
      img[idx] = EST_W'(lo >> 1);
    end
    return img;
  endfunction
endpackage

// File: rtl/rsqrt_lzc.sv
module rsqrt_lzc #(
  parameter int W  = 52,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  // Scan from the bottom; the highest set bit writes last.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rsqrt_rom.sv
module rsqrt_rom
  import rsqrt_pkg::*;
(
  input  logic [IDX_W-1:0] addr,
  output logic [EST_W-1:0] data
);
  localparam romImage_t IMAGE = buildRomImage();

  assign data = IMAGE[addr];
endmodule

// File: rtl/rsqrt_ctrl.sv
module rsqrt_ctrl
  import rsqrt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inSingle,
  output ctrlStrobes_t strb,
  output logic         outValid
);
  always_comb begin
    strb.capture = inValid;
    strb.narrow  = inSingle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/rsqrt_datapath.sv
module rsqrt_datapath
  import rsqrt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DBL_W-1:0]  operand,
  output logic [DBL_W-1:0]  result
);
  logic                  sgn;
  logic [DBL_EXP_W-1:0]  expField;
  logic [DBL_FRAC_W-1:0] fracField;
  logic                  expAllOnes;
  logic                  expAllZero;
  logic                  fracZero;
  opClass_t              opClass;

  // Unpack both formats into one double-shaped view.
  always_comb begin
    if (strb.narrow) begin
      sgn        = operand[SGL_W-1];
      expField   = DBL_EXP_W'(operand[SGL_W-2 -: SGL_EXP_W]);
      fracField  = {operand[SGL_FRAC_W-1:0], {FRAC_PAD{1'b0}}};
      expAllOnes = &operand[SGL_W-2 -: SGL_EXP_W];
    end else begin
      sgn        = operand[DBL_W-1];
      expField   = operand[DBL_W-2 -: DBL_EXP_W];
      fracField  = operand[DBL_FRAC_W-1:0];
      expAllOnes = &operand[DBL_W-2 -: DBL_EXP_W];
    end
    expAllZero = (expField == '0);
    fracZero   = (fracField == '0);
    if (expAllOnes)      opClass = fracZero ? CLS_INF : CLS_NAN;
    else if (expAllZero && fracZero) opClass = CLS_ZERO;
    else                 opClass = CLS_FINITE;
  end

  // Subnormal normalisation: count, then one barrel shift.
  logic [LZ_W-1:0]       lzCount;
  logic [DBL_FRAC_W-1:0] normFrac;
  logic [DBL_FRAC_W-1:0] fracUse;

  rsqrt_lzc #(.W(DBL_FRAC_W), .CW(LZ_W)) u_lzc (
    .vec   (fracField),
    .count (lzCount)
  );

  assign normFrac = (fracField << lzCount) << 1;
  assign fracUse  = expAllZero ? normFrac : fracField;

  // Effective exponent in double bias, signed in two's complement.
  logic [EXP_CALC_W-1:0] biasVal;
  logic [EXP_CALC_W-1:0] expEff;
  logic [DBL_EXP_W-1:0]  resExp;
  logic [SGL_EXP_W-1:0]  narrowExp;
  logic [EST_W-1:0]      fracTop;
  logic [IDX_W-1:0]      romIdx;
  logic [EST_W-1:0]      estimate;

  assign biasVal = strb.narrow ? EXP_CALC_W'(REBIAS) : '0;
  assign expEff  = expAllZero ? (biasVal - EXP_CALC_W'(lzCount))
                              : (EXP_CALC_W'(expField) + biasVal);
  assign resExp    = DBL_EXP_W'((EXP_CALC_W'(EXP_MAGIC) - expEff) >> 1);
  assign narrowExp = SGL_EXP_W'(resExp - DBL_EXP_W'(REBIAS));
  assign fracTop   = EST_W'(fracUse >> EST_LSB);

  // Odd exponents address the lower half, even ones the upper half.
  assign romIdx = expEff[0] ? {2'b01, fracTop[EST_W-1:1]} : {1'b1, fracTop};

  rsqrt_rom u_rom (
    .addr (romIdx),
    .data (estimate)
  );

  logic [DBL_W-1:0] resNext;

  always_comb begin
    if (strb.narrow) begin
      unique case (opClass)
        CLS_ZERO: resNext = {32'b0, sgn, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
        CLS_INF:  resNext = {32'b0, sgn, {(SGL_W-1){1'b0}}};
        CLS_NAN:  resNext = {32'b0, operand[SGL_W-1:0] | (32'd1 << (SGL_FRAC_W-1))};
        default:  resNext = {32'b0, sgn, narrowExp, estimate, {SGL_EST_LSB{1'b0}}};
      endcase
    end else begin
      unique case (opClass)
        CLS_ZERO: resNext = {sgn, {DBL_EXP_W{1'b1}}, {DBL_FRAC_W{1'b0}}};
        CLS_INF:  resNext = {sgn, {(DBL_W-1){1'b0}}};
        CLS_NAN:  resNext = operand | (64'd1 << (DBL_FRAC_W-1));
        default:  resNext = {sgn, resExp, estimate, {EST_LSB{1'b0}}};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (strb.capture) result <= resNext;
  end

  assert_zero_gives_inf_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.narrow && operand[62:0] == '0)
      |=> result[62:0] == {11'h7FF, 52'b0});
  assert_inf_gives_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.narrow && operand[62:0] == {11'h7FF, 52'b0})
      |=> result[62:0] == '0);
  assert_nan_quieted_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.narrow && operand[62:52] == 11'h7FF && operand[51:0] != '0)
      |=> result == ($past(operand) | 64'h0008_0000_0000_0000));
  assert_sign_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.narrow) |=> result[63] == $past(operand[63]));
  assert_low_fraction_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.narrow && operand[62:52] != 11'h7FF && operand[62:0] != '0)
      |=> result[43:0] == '0);
  assert_single_upper_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.narrow) |=> result[63:32] == '0);
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSingle,
  input  logic [63:0] inOperand,
  output logic        outValid,
  output logic [63:0] outResult
);
  ctrlStrobes_t strb;

  rsqrt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSingle (inSingle),
    .strb     (strb),
    .outValid (outValid)
  );

  rsqrt_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .operand (inOperand),
    .result  (outResult)
  );

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outResult));
endmodule

// File: tb/rsqrt_est_bench.sv
`timescale 1ns/1ps
module rsqrt_est_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSingle = 1'b0;
  logic [63:0] inOperand = '0;
  logic        outValid;
  logic [63:0] outResult;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tbl [512];

  always #2.5 clk = ~clk;

  rsqrt_est u_rsqrt_est (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSingle(inSingle),
    .inOperand(inOperand), .outValid(outValid), .outResult(outResult)
  );

  // Linear search table, straight from the R4 rule.
  task automatic buildTable();
    for (int k = 0; k < 512; k++) tbl[k] = 0;
    for (int k = 128; k < 512; k++) begin
      longint a;
      longint b;
      a = (k < 256) ? longint'(2 * k + 1) : longint'((k | 1) << 1);
      b = 256;
      while (a * (b + 1) * (b + 1) < (longint'(1) << 28)) b++;
      tbl[k] = int'(((b + 1) >> 1) & 255);
    end
  endtask

  function automatic logic [63:0] refDouble(input logic [63:0] x);
    logic [63:0] sgn;
    logic [63:0] sc;
    longint e;
    longint rexp;
    int idx;
    sgn = x & 64'h8000_0000_0000_0000;
    e = longint'(x[62:52]);
    sc = {12'b0, x[51:0]};
    if (e == 2047) return (sc == 0) ? sgn : (x | 64'h0008_0000_0000_0000);
    if (e == 0) begin
      if (sc == 0) return sgn | 64'h7FF0_0000_0000_0000;
      while (sc[51] == 1'b0) begin
        sc = sc << 1;
        e = e - 1;
      end
      sc = sc << 1;
    end
    if (e[0]) idx = int'(((sc >> 45) & 64'hFF) | 64'h80);
    else      idx = int'(((sc >> 44) & 64'hFF) | 64'h100);
    rexp = ((3068 - e) / 2) & 2047;
    return sgn | (64'(rexp) << 52) | (64'(tbl[idx]) << 44);
  endfunction

  function automatic logic [63:0] refSingle(input logic [31:0] x);
    logic        s;
    logic [7:0]  se;
    logic [22:0] sf;
    logic [23:0] m;
    logic [63:0] d;
    logic [63:0] r;
    int de;
    s = x[31];
    se = x[30:23];
    sf = x[22:0];
    if (se == 8'hFF) return (sf == 0) ? {32'b0, s, 31'b0} : {32'b0, x | 32'h0040_0000};
    if (se == 0 && sf == 0) return {32'b0, s, 8'hFF, 23'b0};
    if (se == 0) begin
      de = 897;
      m = {1'b0, sf};
      while (m[23] == 1'b0) begin
        m = m << 1;
        de = de - 1;
      end
      d = {s, 11'(de), m[22:0], 29'b0};
    end else begin
      d = {s, 11'(int'(se) + 896), sf, 29'b0};
    end
    r = refDouble(d);
    return {32'b0, r[63], 8'(r[62:52] - 11'd896), r[51:29]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next one with the result checked.
  task automatic runOp(input logic single, input logic [63:0] op, input logic [63:0] exp,
                       input string req);
    inValid = 1'b1;
    inSingle = single;
    inOperand = op;
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " valid"}, {63'b0, outValid}, 64'd1);
    chk(req, outResult, exp);
  endtask

  task automatic runDouble(input logic [63:0] op, input string req);
    runOp(1'b0, op, refDouble(op), req);
  endtask

  task automatic runSingle(input logic [63:0] op, input string req);
    runOp(1'b1, op, refSingle(op[31:0]), req);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240613));
    buildTable();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", {63'b0, outValid}, 64'd0);
    chk("R1 reset result", outResult, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 / R3 directed values worked out by hand
    runOp(1'b0, 64'h3FF0_0000_0000_0000, 64'h3FEF_F000_0000_0000, "R4 one");
    runOp(1'b0, 64'h4010_0000_0000_0000, 64'h3FDF_F000_0000_0000, "R3 four");
    runOp(1'b0, 64'hBFF0_0000_0000_0000, 64'hBFEF_F000_0000_0000, "R3 negative sign");
    // R9 anchor value and ignored upper half
    runOp(1'b1, 64'h0000_0000_4120_0000, 64'h0000_0000_3EA1_8000, "R9 ten");
    runOp(1'b1, 64'hDEAD_BEEF_4120_0000, 64'h0000_0000_3EA1_8000, "R9 upper ignored");
    // R5 R6 R7
    runOp(1'b0, 64'h0000_0000_0000_0000, 64'h7FF0_0000_0000_0000, "R5 +zero");
    runOp(1'b0, 64'h8000_0000_0000_0000, 64'hFFF0_0000_0000_0000, "R5 -zero");
    runOp(1'b0, 64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, "R6 +inf");
    runOp(1'b0, 64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000, "R6 -inf");
    runOp(1'b0, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, "R7 signalling");
    runOp(1'b0, 64'hFFF8_1234_5678_9ABC, 64'hFFF8_1234_5678_9ABC, "R7 quiet");
    // R8 subnormal extremes
    runOp(1'b0, 64'h0000_0000_0000_0001, 64'h617F_F000_0000_0000, "R8 smallest");
    runDouble(64'h000F_FFFF_FFFF_FFFF, "R8 largest");
    runDouble(64'h7FEF_FFFF_FFFF_FFFF, "R3 max normal");
    runDouble(64'h0010_0000_0000_0000, "R3 min normal");
    // R10 single specials
    runOp(1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_7F80_0000, "R10 +zero");
    runOp(1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_FF80_0000, "R10 -zero");
    runOp(1'b1, 64'h0000_0000_FF80_0000, 64'h0000_0000_8000_0000, "R10 -inf");
    runOp(1'b1, 64'h0000_0000_7F80_0001, 64'h0000_0000_7FC0_0001, "R10 nan");
    // R11 single subnormal extremes
    runSingle(64'h0000_0000_0000_0001, "R11 smallest");
    runSingle(64'h0000_0000_007F_FFFF, "R11 largest");

    // R2: idle cycles with busy inputs leave the result alone
    for (int i = 0; i < 8; i++) begin
      held = outResult;
      inValid = 1'b0;
      inSingle = i[0];
      inOperand = rnd64();
      @(negedge clk);
      chk("R2 idle valid", {63'b0, outValid}, 64'd0);
      chk("R2 idle hold", outResult, held);
      runDouble(rnd64(), "R3 after idle");
    end

    // Random sweeps
    for (int i = 0; i < 300; i++) begin
      logic [63:0] v;
      v = rnd64();
      v[62:52] = 11'(1 + ($urandom % 2046));
      runDouble(v, "R3 random normal");
    end
    for (int i = 0; i < 200; i++) begin
      logic [63:0] v;
      v = rnd64();
      v[62:52] = 11'd0;
      v[51:0] = v[51:0] >> ($urandom % 52);
      if (v[51:0] == 0) v[0] = 1'b1;
      runDouble(v, "R8 random subnormal");
    end
    for (int i = 0; i < 300; i++) begin
      logic [63:0] v;
      v = rnd64();
      v[30:23] = 8'(1 + ($urandom % 254));
      runSingle(v, "R9 random normal");
    end
    for (int i = 0; i < 200; i++) begin
      logic [63:0] v;
      v = rnd64();
      v[30:23] = 8'd0;
      v[22:0] = v[22:0] >> ($urandom % 23);
      if (v[22:0] == 0) v[0] = 1'b1;
      runSingle(v, "R11 random subnormal");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule